// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This engine takes a byte-address range and a maintenance operation, which is invalidate, clean, or clean-and-invalidate ("flush"). It turns the request into the register writes that a cache controller expects.

For ranges smaller than the cache it walks the range one 32-byte line at a time. Before each line command it reads the controller's line-operation register until the busy bit clears. It breaks the walk into chunks of at most 4096 bytes and gives up the controller for a cycle between chunks, so that an arbiter can slip other traffic in. A clean or flush that covers at least the whole cache becomes one whole-cache way-mask command instead.

Every request, even an empty one, finishes with a drain of the line register, a sync write, and a wait until the sync busy bit clears. After that the engine pulses `done`.

The engine is used by a requester that raises `req_valid` for one cycle while `busy` is low. The register port is a plain master. A read data word returns on `reg_rdata` in the cycle after `reg_rd`, and a write is a single cycle of `reg_wr`.

Top module: `cmo_range_engine`

## Requirements
- R1: Operation codes are 0 = invalidate, 1 = clean, 2 and 3 = flush. Line commands go to offset 0x10 (invalidate), 0x14 (clean) or 0x18 (flush). Each line command's data is the line address with the low 5 bits cleared.
- R2: For invalidate, the edge lines are handled first and then the body:
  - If the start is not line-aligned, a flush command to 0x18 on the start's line is issued first.
  - If the end is not line-aligned, a flush command to 0x18 on the end's line comes next.
  - Plain invalidates then cover every line from the line after an unaligned start, or the start itself if aligned, up to but not including the aligned-down end.
- R3: For clean and flush, the start is aligned down and one command is issued per line, in ascending order, until the line address reaches the end.
- R4: A clean or flush with (end - start) >= `cfg_cache_bytes` is replaced by a whole-cache command:
  - One write of `cfg_way_mask` goes to 0x20 (clean) or 0x24 (flush).
  - That register is then read until all mask bits are zero.
  - Invalidate requests never take this path.
- R5: Before every line command, the target line register is read until bit 0 is zero. No line command is written while the controller still reports that register busy.
- R6: A request ends in this order:
  - The line register is read until bit 0 clears (range path only).
  - 0 is written to the sync register at offset 0x00.
  - The sync register is read until bit 0 clears.
  - `done` pulses high for exactly one cycle.
- R7: The line walk is split into chunks of at most 4096 bytes. While busy, `port_hold` is high except for exactly one cycle between consecutive chunks.
- R8: During a flush line walk, 0x03 is written to the debug register at offset 0x30 before each chunk, and 0x00 is written there after it.
- R9: A request with end <= start issues only the sync step and then `done`.
- R10: `busy` goes high the cycle after a request is accepted and stays high through the `done` cycle. A `req_valid` while busy is ignored: no command and no second `done` comes from it.
- R11: `reg_rd` and `reg_wr` are never high together, and both stay low while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 2 | Operation code (R1) |
| req_start | input | AW | First byte address of the range |
| req_end | input | AW | Byte address just past the range |
| cfg_cache_bytes | input | AW | Total cache size in bytes |
| cfg_way_mask | input | DW | Mask of active ways |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| port_hold | output | 1 | Engine owns the controller port |
| reg_addr | output | RAW | Register offset |
| reg_wdata | output | DW | Register write data |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | DW | Read data, valid the cycle after reg_rd |

## Verification
The checker watches the port-level rules on every cycle:
- read and write strobes are exclusive, and the port is quiet when idle;
- `done` is a single pulse, is always preceded by a sync write, and is followed by `busy` dropping;
- an accepted request raises `busy`;
- a `port_hold` gap never lasts more than one cycle.

The bench's scenarios are the only way to show the content of the command stream. That covers the order of the edge flushes for invalidate, line counts and alignment, the whole-cache threshold, the chunk count, the debug bracketing, and the fact that no line command lands while the modelled controller is still busy.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

   typedef enum logic [1:0] {
      OP_INV   = 2'd0,
      OP_CLEAN = 2'd1,
      OP_FLUSH = 2'd2,
      OP_FLUSH_ALT = 2'd3
   } cmo_op_e;

   // controller register offsets
   localparam int unsigned OFS_SYNC       = 'h00;
   localparam int unsigned OFS_INV_LINE   = 'h10;
   localparam int unsigned OFS_CLEAN_LINE = 'h14;
   localparam int unsigned OFS_CINV_LINE  = 'h18;
   localparam int unsigned OFS_CLEAN_WAY  = 'h20;
   localparam int unsigned OFS_CINV_WAY   = 'h24;
   localparam int unsigned OFS_DEBUG      = 'h30;
   localparam int unsigned OFS_MAX        = 'h30;

   localparam int unsigned DBG_ON_VAL  = 'h03;
   localparam int unsigned DBG_OFF_VAL = 'h00;

   typedef enum logic [3:0] {
      S_IDLE, S_HEAD, S_TAIL, S_CHUNK, S_DBG_ON, S_LINE,
      S_DBG_OFF, S_PAUSE, S_DRAIN, S_WAY, S_SYNC, S_DONE
   } seq_state_e;

endpackage

// File: rtl/cmo_reg_port.sv
module cmo_reg_port #(
   parameter int RAW = 8,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [RAW-1:0] cmd_addr,
   input  logic [DW-1:0]  cmd_wdata,
   input  logic [DW-1:0]  cmd_mask,
   input  logic           cmd_pre,
   input  logic           cmd_wr,
   input  logic           cmd_post,
   output logic           cmd_done,
   output logic [RAW-1:0] reg_addr,
   output logic [DW-1:0]  reg_wdata,
   output logic           reg_wr,
   output logic           reg_rd,
   input  logic [DW-1:0]  reg_rdata
);

   typedef enum logic [2:0] {
      P_IDLE, P_PRE_RD, P_PRE_CHK, P_WR, P_POST_RD, P_POST_CHK, P_FIN
   } port_state_e;

   port_state_e    pst;
   logic [RAW-1:0] addr_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  mask_q;
   logic           wr_q;
   logic           post_q;
   logic           still_busy;

   assign still_busy = |(reg_rdata & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pst     <= P_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
         wr_q    <= 1'b0;
         post_q  <= 1'b0;
      end else begin
         unique case (pst)
            P_IDLE: if (cmd_valid) begin
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               mask_q  <= cmd_mask;
               wr_q    <= cmd_wr;
               post_q  <= cmd_post;
               if (cmd_pre)       pst <= P_PRE_RD;
               else if (cmd_wr)   pst <= P_WR;
               else if (cmd_post) pst <= P_POST_RD;
               else               pst <= P_FIN;
            end
            P_PRE_RD:  pst <= P_PRE_CHK;
            P_PRE_CHK: begin
               if (still_busy) pst <= P_PRE_RD;
               else if (wr_q)  pst <= P_WR;
               else if (post_q) pst <= P_POST_RD;
               else            pst <= P_FIN;
            end
            P_WR:       pst <= post_q ? P_POST_RD : P_FIN;
            P_POST_RD:  pst <= P_POST_CHK;
            P_POST_CHK: pst <= still_busy ? P_POST_RD : P_FIN;
            P_FIN:      pst <= P_IDLE;
            default:    pst <= P_IDLE;
         endcase
      end
   end

   assign reg_addr  = addr_q;
   assign reg_wdata = wdata_q;
   assign reg_rd    = (pst == P_PRE_RD) || (pst == P_POST_RD);
   assign reg_wr    = (pst == P_WR);
   assign cmd_done  = (pst == P_FIN);

endmodule

// File: rtl/cmo_range_plan.sv
module cmo_range_plan
   import cmo_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 32
) (
   input  cmo_op_e         op,
   input  logic [AW-1:0]   rs,
   input  logic [AW-1:0]   re,
   input  logic [AW-1:0]   cache_bytes,
   output logic            empty,
   output logic            whole,
   output logic            head_need,
   output logic            tail_need,
   output logic [AW-1:0]   head_line,
   output logic [AW-1:0]   tail_line,
   output logic [AW-1:0]   first_line,
   output logic [AW-1:0]   limit
);

   localparam int LW = $clog2(LINE_BYTES);
   localparam logic [AW-1:0] LINE_STEP = AW'(LINE_BYTES);

   logic          is_inv;
   logic [AW-1:0] span;
   logic [AW-1:0] rs_al;
   logic [AW-1:0] re_al;

   assign is_inv = (op == OP_INV);
   assign span   = re - rs;
   assign rs_al  = {rs[AW-1:LW], {LW{1'b0}}};
   assign re_al  = {re[AW-1:LW], {LW{1'b0}}};

   assign empty      = (re <= rs);
   assign whole      = !empty && !is_inv && (span >= cache_bytes);
   assign head_need  = is_inv && (rs[LW-1:0] != '0);
   assign tail_need  = is_inv && (re[LW-1:0] != '0);
   assign head_line  = rs_al;
   assign tail_line  = re_al;
   assign first_line = head_need ? rs_al + LINE_STEP : rs_al;
   assign limit      = is_inv ? re_al : re;

endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
   import cmo_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int RAW         = 8,
   parameter int LINE_BYTES  = 32,
   parameter int CHUNK_BYTES = 4096,
   parameter int FLUSH_DEBUG = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [1:0]     req_op,
   input  logic [AW-1:0]  req_start,
   input  logic [AW-1:0]  req_end,
   input  logic [AW-1:0]  cfg_cache_bytes,
   input  logic [DW-1:0]  cfg_way_mask,
   output logic           busy,
   output logic           done,
   output logic           port_hold,
   output logic [RAW-1:0] reg_addr,
   output logic [DW-1:0]  reg_wdata,
   output logic           reg_wr,
   output logic           reg_rd,
   input  logic [DW-1:0]  reg_rdata
);

   localparam logic [AW-1:0] LINE_STEP  = AW'(LINE_BYTES);
   localparam logic [AW-1:0] CHUNK_SPAN = AW'(CHUNK_BYTES);
   localparam logic [DW-1:0] BIT0       = DW'(1);

   generate
      if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 4");
      end
      if (CHUNK_BYTES < LINE_BYTES || (CHUNK_BYTES % LINE_BYTES) != 0) begin : g_bad_chunk
         $error("CHUNK_BYTES must be a multiple of LINE_BYTES");
      end
      if (DW < AW) begin : g_bad_dw
         $error("DW must hold a full address");
      end
      if ((1 << RAW) <= OFS_MAX) begin : g_bad_raw
         $error("RAW too narrow for the register offsets");
      end
   endgenerate

   seq_state_e     st;
   cmo_op_e        op_q;
   logic [AW-1:0]  cur, lim, blk;
   logic [AW-1:0]  head_line_q, tail_line_q;
   logic           tail_need_q;
   logic           inflight;
   logic           dbg_en;

   // planner outputs
   logic           pl_empty, pl_whole, pl_head, pl_tail;
   logic [AW-1:0]  pl_head_line, pl_tail_line, pl_first, pl_limit;

   cmo_range_plan #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_plan (
      .op          (cmo_op_e'(req_op)),
      .rs          (req_start),
      .re          (req_end),
      .cache_bytes (cfg_cache_bytes),
      .empty       (pl_empty),
      .whole       (pl_whole),
      .head_need   (pl_head),
      .tail_need   (pl_tail),
      .head_line   (pl_head_line),
      .tail_line   (pl_tail_line),
      .first_line  (pl_first),
      .limit       (pl_limit)
   );

   generate
      if (FLUSH_DEBUG != 0) begin : g_dbg
         assign dbg_en = op_q[1];
      end else begin : g_nodbg
         assign dbg_en = 1'b0;
      end
   endgenerate

   // command to the port engine
   logic           cmd_valid, cmd_done, is_cmd;
   logic [RAW-1:0] cmd_addr;
   logic [DW-1:0]  cmd_wdata, cmd_mask;
   logic           cmd_pre, cmd_wr, cmd_post;
   logic [RAW-1:0] line_reg, way_reg;

   always_comb begin
      unique case (op_q)
         OP_INV:   line_reg = RAW'(OFS_INV_LINE);
         OP_CLEAN: line_reg = RAW'(OFS_CLEAN_LINE);
         default:  line_reg = RAW'(OFS_CINV_LINE);
      endcase
      way_reg = (op_q == OP_CLEAN) ? RAW'(OFS_CLEAN_WAY) : RAW'(OFS_CINV_WAY);
   end

   always_comb begin
      is_cmd    = 1'b1;
      cmd_addr  = line_reg;
      cmd_wdata = '0;
      cmd_mask  = BIT0;
      cmd_pre   = 1'b0;
      cmd_wr    = 1'b0;
      cmd_post  = 1'b0;
      unique case (st)
         S_HEAD: begin
            cmd_addr = RAW'(OFS_CINV_LINE); cmd_wdata = DW'(head_line_q);
            cmd_pre = 1'b1; cmd_wr = 1'b1;
         end
         S_TAIL: begin
            cmd_addr = RAW'(OFS_CINV_LINE); cmd_wdata = DW'(tail_line_q);
            cmd_pre = 1'b1; cmd_wr = 1'b1;
         end
         S_DBG_ON: begin
            cmd_addr = RAW'(OFS_DEBUG); cmd_wdata = DW'(DBG_ON_VAL); cmd_wr = 1'b1;
         end
         S_DBG_OFF: begin
            cmd_addr = RAW'(OFS_DEBUG); cmd_wdata = DW'(DBG_OFF_VAL); cmd_wr = 1'b1;
         end
         S_LINE: begin
            cmd_wdata = DW'(cur); cmd_pre = 1'b1; cmd_wr = 1'b1;
         end
         S_DRAIN: cmd_pre = 1'b1;
         S_WAY: begin
            cmd_addr = way_reg; cmd_wdata = cfg_way_mask; cmd_mask = cfg_way_mask;
            cmd_wr = 1'b1; cmd_post = 1'b1;
         end
         S_SYNC: begin
            cmd_addr = RAW'(OFS_SYNC); cmd_wr = 1'b1; cmd_post = 1'b1;
         end
         default: is_cmd = 1'b0;
      endcase
   end

   assign cmd_valid = is_cmd && !inflight;

   cmo_reg_port #(.RAW(RAW), .DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .cmd_mask  (cmd_mask),
      .cmd_pre   (cmd_pre),
      .cmd_wr    (cmd_wr),
      .cmd_post  (cmd_post),
      .cmd_done  (cmd_done),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   logic [AW-1:0] cur_next, rem;
   logic          more_chunks;
   assign cur_next    = cur + LINE_STEP;
   assign rem         = lim - cur;
   assign more_chunks = (blk < lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         op_q        <= OP_INV;
         cur         <= '0;
         lim         <= '0;
         blk         <= '0;
         head_line_q <= '0;
         tail_line_q <= '0;
         tail_need_q <= 1'b0;
         inflight    <= 1'b0;
      end else begin
         if (cmd_valid)     inflight <= 1'b1;
         else if (cmd_done) inflight <= 1'b0;
         unique case (st)
            S_IDLE: if (req_valid) begin
               op_q        <= cmo_op_e'(req_op);
               cur         <= pl_first;
               lim         <= pl_limit;
               head_line_q <= pl_head_line;
               tail_line_q <= pl_tail_line;
               tail_need_q <= pl_tail;
               if (pl_empty)      st <= S_SYNC;
               else if (pl_whole) st <= S_WAY;
               else if (pl_head)  st <= S_HEAD;
               else if (pl_tail)  st <= S_TAIL;
               else               st <= S_CHUNK;
            end
            S_HEAD: if (cmd_done) st <= tail_need_q ? S_TAIL : S_CHUNK;
            S_TAIL: if (cmd_done) st <= S_CHUNK;
            S_CHUNK: begin
               if (cur >= lim) st <= S_DRAIN;
               else begin
                  blk <= cur + ((rem > CHUNK_SPAN) ? CHUNK_SPAN : rem);
                  st  <= dbg_en ? S_DBG_ON : S_LINE;
               end
            end
            S_DBG_ON: if (cmd_done) st <= S_LINE;
            S_LINE: if (cmd_done) begin
               cur <= cur_next;
               if (cur_next >= blk)
                  st <= dbg_en ? S_DBG_OFF : (more_chunks ? S_PAUSE : S_DRAIN);
            end
            S_DBG_OFF: if (cmd_done) st <= more_chunks ? S_PAUSE : S_DRAIN;
            S_PAUSE:   st <= S_CHUNK;
            S_DRAIN:   if (cmd_done) st <= S_SYNC;
            S_WAY:     if (cmd_done) st <= S_SYNC;
            S_SYNC:    if (cmd_done) st <= S_DONE;
            S_DONE:    st <= S_IDLE;
            default:   st <= S_IDLE;
         endcase
      end
   end

   assign busy      = (st != S_IDLE);
   assign done      = (st == S_DONE);
   assign port_hold = busy && (st != S_PAUSE);

endmodule

// File: rtl/cmo_range_engine_chk.sv
module cmo_range_engine_chk
   import cmo_pkg::*;
#(
   parameter int RAW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           busy,
   input logic           done,
   input logic           port_hold,
   input logic           reg_wr,
   input logic           reg_rd,
   input logic [RAW-1:0] reg_addr
);

   logic sync_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   sync_seen <= 1'b0;
      else if (done)                                sync_seen <= 1'b0;
      else if (reg_wr && reg_addr == RAW'(OFS_SYNC)) sync_seen <= 1'b1;
   end

   assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_wr && !reg_rd));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_sync_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sync_seen);

   assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   assert_hold_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_hold |-> busy);

   assert_hold_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !port_hold) |=> port_hold);

endmodule

bind cmo_range_engine cmo_range_engine_chk #(.RAW(RAW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .port_hold (port_hold),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr)
);

// File: tb/cmo_range_engine_test.sv
`timescale 1ns/1ps
module cmo_range_engine_test;

   localparam logic [7:0] A_SYNC = 8'h00, A_INV = 8'h10, A_CLN = 8'h14, A_CINV = 8'h18;
   localparam logic [7:0] A_CLN_WAY = 8'h20, A_CINV_WAY = 8'h24, A_DBG = 8'h30;
   localparam int LOGN = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_start = '0, req_end = '0;
   logic [31:0] cfg_cache_bytes = 32'h10000;
   logic [31:0] cfg_way_mask = 32'hFF;
   logic        busy, done, port_hold, reg_wr, reg_rd;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   always #5 clk = ~clk;

   cmo_range_engine uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_start(req_start), .req_end(req_end), .cfg_cache_bytes(cfg_cache_bytes),
      .cfg_way_mask(cfg_way_mask), .busy(busy), .done(done), .port_hold(port_hold),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   // controller model and monitors
   int          line_cnt, way_cnt, sync_cnt;
   logic [31:0] way_val;
   int          viol, done_cnt, pause_cnt, log_n;
   logic [7:0]  log_a [0:LOGN-1];
   logic [31:0] log_d [0:LOGN-1];
   logic [7:0]  exp_a [0:LOGN-1];
   logic [31:0] exp_d [0:LOGN-1];
   int          exp_n, exp_pause;
   int          tests, fails;
   longint      cyc;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         reg_rdata <= '0;
         line_cnt <= 0; way_cnt <= 0; sync_cnt <= 0; way_val <= '0;
      end else begin
         if (reg_rd) begin
            if (reg_addr == A_INV || reg_addr == A_CLN || reg_addr == A_CINV) begin
               reg_rdata <= (line_cnt != 0) ? 32'h1 : 32'h0;
               if (line_cnt != 0) line_cnt <= line_cnt - 1;
            end else if (reg_addr == A_CLN_WAY || reg_addr == A_CINV_WAY) begin
               reg_rdata <= (way_cnt != 0) ? way_val : 32'h0;
               if (way_cnt != 0) way_cnt <= way_cnt - 1;
            end else if (reg_addr == A_SYNC) begin
               reg_rdata <= (sync_cnt != 0) ? 32'h1 : 32'h0;
               if (sync_cnt != 0) sync_cnt <= sync_cnt - 1;
            end else reg_rdata <= 32'h0;
         end
         if (reg_wr) begin
            if (log_n < LOGN) begin
               log_a[log_n] <= reg_addr;
               log_d[log_n] <= reg_wdata;
            end
            log_n <= log_n + 1;
            if (reg_addr == A_INV || reg_addr == A_CLN || reg_addr == A_CINV) begin
               if (line_cnt != 0) viol <= viol + 1;
               line_cnt <= 2;
            end else if (reg_addr == A_CLN_WAY || reg_addr == A_CINV_WAY) begin
               way_cnt <= 3; way_val <= reg_wdata;
            end else if (reg_addr == A_SYNC) begin
               if (line_cnt != 0) viol <= viol + 1;
               sync_cnt <= 2;
            end
         end
         if (done) begin
            done_cnt <= done_cnt + 1;
            if (sync_cnt != 0 || way_cnt != 0) viol <= viol + 1;
         end
         if (busy && !port_hold) pause_cnt <= pause_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic push(input logic [7:0] a, input logic [31:0] d);
      if (exp_n < LOGN) begin exp_a[exp_n] = a; exp_d[exp_n] = d; end
      exp_n++;
   endtask

   // expected command stream derived from the requirements
   task automatic build_exp(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e);
      logic [31:0] c, l, b, lreg;
      exp_n = 0; exp_pause = 0;
      if (e <= s) begin
         push(A_SYNC, 0);
         return;
      end
      if (op != 2'd0 && (e - s) >= cfg_cache_bytes) begin
         push(op == 2'd1 ? A_CLN_WAY : A_CINV_WAY, cfg_way_mask);
         push(A_SYNC, 0);
         return;
      end
      if (op == 2'd0) begin
         c = s; l = e;
         if (c[4:0] != 0) begin c = {c[31:5], 5'b0}; push(A_CINV, c); c = c + 32; end
         if (l[4:0] != 0) begin l = {l[31:5], 5'b0}; push(A_CINV, l); end
      end else begin
         c = {s[31:5], 5'b0}; l = e;
      end
      lreg = (op == 2'd0) ? A_INV : (op == 2'd1) ? A_CLN : A_CINV;
      while (c < l) begin
         b = c + (((l - c) > 4096) ? 4096 : (l - c));
         if (op[1]) push(A_DBG, 3);
         while (c < b) begin push(lreg[7:0], c); c = c + 32; end
         if (op[1]) push(A_DBG, 0);
         if (b < l) exp_pause++;
      end
      push(A_SYNC, 0);
   endtask

   task automatic clear_mon();
      @(negedge clk);
      log_n = 0; viol = 0; done_cnt = 0; pause_cnt = 0;
   endtask

   task automatic issue(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e);
      @(negedge clk);
      req_op = op; req_start = s; req_end = e; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 40000 && done_cnt == 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic verify(input string tag);
      int bad;
      bad = -1;
      check(log_n == exp_n, {tag, " write count"}, log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n && i < LOGN; i++)
         if (bad < 0 && (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i])) bad = i;
      if (bad >= 0)
         check(1'b0, {tag, " write content"}, {log_a[bad], log_d[bad]}, {exp_a[bad], exp_d[bad]});
      else check(1'b1, tag, 0, 0);
      check(pause_cnt == exp_pause, {tag, " R7 hold gaps"}, pause_cnt, exp_pause);
      check(done_cnt == 1, {tag, " R6 done pulses"}, done_cnt, 1);
      check(viol == 0, {tag, " R5 poll before write"}, viol, 0);
      check(busy == 1'b0, {tag, " R10 busy released"}, busy, 0);
   endtask

   task automatic run(input string tag, input logic [1:0] op, input logic [31:0] s, input logic [31:0] e);
      clear_mon();
      issue(op, s, e);
      wait_done();
      build_exp(op, s, e);
      verify(tag);
   endtask

   task automatic test_reset();
      check(busy == 0 && done == 0 && port_hold == 0, "R10 reset idle", {busy, done, port_hold}, 0);
      check(reg_wr == 0 && reg_rd == 0, "R11 reset quiet", {reg_wr, reg_rd}, 0);
   endtask

   task automatic test_inv_aligned();   run("R1 inv aligned", 2'd0, 32'h1000, 32'h1080); endtask
   task automatic test_inv_edges();     run("R2 inv edges", 2'd0, 32'h1004, 32'h1068); endtask
   task automatic test_inv_same_line(); run("R2 inv one line", 2'd0, 32'h1021, 32'h103F); endtask
   task automatic test_clean_unal();    run("R3 clean unaligned", 2'd1, 32'h2010, 32'h2050); endtask
   task automatic test_flush_chunks();  run("R8 flush chunks", 2'd2, 32'h0, 32'h2040); endtask
   task automatic test_chunk_exact();   run("R7 exact chunk", 2'd0, 32'h8000, 32'h9000); endtask
   task automatic test_empty();         run("R9 empty", 2'd1, 32'h3000, 32'h3000); endtask
   task automatic test_reverse();       run("R9 reversed", 2'd2, 32'h3100, 32'h3000); endtask

   task automatic test_whole();
      run("R4 whole clean", 2'd1, 32'h0, 32'h10000);
      cfg_way_mask = 32'h0F;
      run("R4 whole flush", 2'd3, 32'h100, 32'h20000);
      cfg_way_mask = 32'hFF;
   endtask

   task automatic test_threshold();
      cfg_cache_bytes = 32'h2000;
      run("R4 below size", 2'd1, 32'h4000, 32'h5FE0);
      run("R4 at size", 2'd2, 32'h4000, 32'h6000);
      run("R4 inv no fallback", 2'd0, 32'h4000, 32'h6000);
      cfg_cache_bytes = 32'h10000;
   endtask

   task automatic test_ignore();
      clear_mon();
      issue(2'd2, 32'h0, 32'h2040);
      check(busy == 1'b1, "R10 busy after accept", busy, 1);
      repeat (20) @(negedge clk);
      req_op = 2'd1; req_start = 32'h9000; req_end = 32'h9100; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      repeat (200) @(negedge clk);
      build_exp(2'd2, 32'h0, 32'h2040);
      verify("R10 ignore while busy");
   endtask

   initial begin
      cyc = 0; tests = 0; fails = 0;
      log_n = 0; viol = 0; done_cnt = 0; pause_cnt = 0;
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_inv_aligned();
      test_inv_edges();
      test_inv_same_line();
      test_clean_unal();
      test_flush_chunks();
      test_chunk_exact();
      test_empty();
      test_reverse();
      test_whole();
      test_threshold();
      test_ignore();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule